// File: doc/BRIEF.md
# Receiver Configuration Power-Up Sequencer

This block brings a low-frequency receiver chip from power-off to a configured, listening state without help from software. When it receives a start pulse, it turns on the receiver's supply and waits for the supply-good indication. It then lets the chip settle for a fixed time before it touches the serial link. After that it sends two command transfers, a chip reset and a clamp release. It finishes by writing seven configuration registers. The first six come from one of two built-in profiles. The seventh holds a column check byte derived from the first six.

The serial traffic itself is produced by a separate serial master. This block hands that master one transfer at a time. Each transfer carries a kind flag, a register address and a data byte, and moves through a request/done handshake. A ready flag reports that the chip is configured. A sleep pulse removes power at any point and waits for the supply to collapse before the block accepts a new start.

Top module: `rxcfg_sequencer`

## Requirements
- R1: While reset is held and right after it, `pwrEn`, `xferReq` and `ready` are low.
- R2: A start pulse while idle or ready raises `pwrEn` on the next cycle. No transfer is requested while `pwrGood` stays low.
- R3: After `pwrGood` is seen high, the block waits `CLK_HZ/1000*SETTLE_MS` clock cycles before it raises `xferReq`. Its tolerance is +2 cycles for sampling.
- R4: `xferReq` stays high with `xferIsCfg`, `xferAddr` and `xferByte` unchanged until a cycle with `xferDone` high. In the cycle after that, `xferReq` is low. Each request carries exactly one transfer.
- R5: Transfers run in this fixed order. First come command 0xA0 and then command 0x20, both with `xferIsCfg`=0 and `xferAddr`=0; the master appends a 0x00 dummy byte to each. Then come configuration writes to addresses 0,1,2,3,4,5,6 in that order, with `xferIsCfg`=1.
- R6: With `profileSel`=0 at start (normal profile), registers 0..5 receive 0xA4, 0x00, 0x00, 0x00, 0x00, 0x9F.
- R7: With `profileSel`=1 at start (signal-strength profile), registers 0..5 receive 0xA8, 0x80, 0x00, 0x00, 0x00, 0xD0.
- R8: Register 6 receives the bitwise inverse of the XOR of the six bytes written to registers 0..5. This is 0xC4 for the normal profile and 0x07 for the signal-strength profile.
- R9: The profile is captured on the start pulse. Changes on `profileSel` during the sequence do not alter any transfer.
- R10: `ready` rises in the cycle after the register 6 transfer completes, with `pwrEn` still high. It is cleared by a sleep pulse or by a new start pulse.
- R11: A start pulse is ignored while power-up, settling or transfers are in progress. It is also ignored while waiting for the supply to fall after sleep. The sequence continues unchanged, and after power-off `pwrEn` stays low.
- R12: A sleep pulse in any state except the power-down wait drops `pwrEn`, `xferReq` and `ready` on the next cycle. Sleep takes priority over a simultaneous start. The block then returns to idle only once `pwrGood` reads low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle pulse: power up and configure |
| sleepReq | input | 1 | One-cycle pulse: remove receiver power |
| profileSel | input | 1 | 0 = normal profile, 1 = signal-strength profile |
| pwrGood | input | 1 | Receiver supply status, high when powered |
| pwrEn | output | 1 | Receiver supply enable |
| xferReq | output | 1 | Transfer request to the serial master |
| xferIsCfg | output | 1 | 0 = command byte, 1 = register write |
| xferAddr | output | 4 | Register address for register writes, 0 for commands |
| xferByte | output | 8 | Command byte or register data |
| xferDone | input | 1 | One-cycle completion pulse from the serial master |
| ready | output | 1 | Receiver configured and powered |

## Verification
The hardest situations to reach are the ones that collide with a live sequence. These are a start pulse arriving partway through the transfers, a profile flip after capture, and a sleep pulse landing mid-transfer and coinciding with a start. They are followed by a start issued while the supply is still decaying. The stimulus gets there with a responder that waits for a chosen transfer count before firing the disturbing pulse. A supply model with a programmable lag keeps `pwrGood` high for several cycles after `pwrEn` falls. Random serial-master latencies and random profiles across repeated runs cover the ordering and the check byte.

// File: rtl/rxcfg_pkg.sv
package rxcfg_pkg;

  localparam int NUM_CMDS  = 2;
  localparam int NUM_CFG   = 6;
  localparam int NUM_STEPS = NUM_CMDS + NUM_CFG + 1;
  localparam int STEP_W    = $clog2(NUM_STEPS + 1);

  localparam logic [7:0] CMD_CHIP_RESET = 8'hA0;
  localparam logic [7:0] CMD_CLAMP_OFF  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWRUP,
    ST_SETTLE,
    ST_ISSUE,
    ST_GAP,
    ST_READY,
    ST_PWRDN
  } seqState_t;

  typedef struct packed {
    logic latchProfile;
    logic clrTimer;
    logic runTimer;
    logic clrStep;
    logic incStep;
  } seqStrobe_t;

  // Configuration byte idx (0..NUM_CFG-1) of a profile
  function automatic logic [7:0] profileByte(input logic strength, input int idx);
    logic [7:0] b;
    b = 8'h00;
    if (!strength) begin
      if (idx == 0) b = 8'hA4;
      else if (idx == NUM_CFG - 1) b = 8'h9F;
    end else begin
      if (idx == 0) b = 8'hA8;
      else if (idx == 1) b = 8'h80;
      else if (idx == NUM_CFG - 1) b = 8'hD0;
    end
    return b;
  endfunction

endpackage

// File: rtl/rxcfg_ctrl.sv
module rxcfg_ctrl
  import rxcfg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       sleepReq,
  input  logic       pwrGood,
  input  logic       xferDone,
  input  logic       timerDone,
  input  logic       lastStep,
  output seqStrobe_t strobe,
  output logic       pwrEn,
  output logic       xferReq,
  output logic       ready
);

  seqState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (sleepReq && state != ST_PWRDN) begin
      stateNext = ST_PWRDN;
    end else begin
      unique case (state)
        ST_IDLE, ST_READY: begin
          if (startReq) begin
            stateNext           = ST_PWRUP;
            strobe.latchProfile = 1'b1;
          end
        end
        ST_PWRUP: begin
          if (pwrGood) begin
            stateNext       = ST_SETTLE;
            strobe.clrTimer = 1'b1;
          end
        end
        ST_SETTLE: begin
          strobe.runTimer = 1'b1;
          if (timerDone) begin
            stateNext      = ST_ISSUE;
            strobe.clrStep = 1'b1;
          end
        end
        ST_ISSUE: begin
          if (xferDone) begin
            if (lastStep) begin
              stateNext = ST_READY;
            end else begin
              stateNext      = ST_GAP;
              strobe.incStep = 1'b1;
            end
          end
        end
        ST_GAP:   stateNext = ST_ISSUE;
        ST_PWRDN: if (!pwrGood) stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    pwrEn   = (state == ST_PWRUP) || (state == ST_SETTLE) || (state == ST_ISSUE)
           || (state == ST_GAP)   || (state == ST_READY);
    xferReq = (state == ST_ISSUE);
    ready   = (state == ST_READY);
  end

endmodule

// File: rtl/rxcfg_datapath.sv
module rxcfg_datapath
  import rxcfg_pkg::*;
#(
  parameter int SETTLE_CYC = 500000
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       profileSel,
  output logic       timerDone,
  output logic       lastStep,
  output logic       xferIsCfg,
  output logic [3:0] xferAddr,
  output logic [7:0] xferByte
);

  localparam int TIMER_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [TIMER_W-1:0] TIMER_LAST = TIMER_W'(SETTLE_CYC - 1);
  localparam logic [STEP_W-1:0]  STEP_LAST  = STEP_W'(NUM_STEPS - 1);
  localparam logic [STEP_W-1:0]  STEP_CFG0  = STEP_W'(NUM_CMDS);

  logic [TIMER_W-1:0] timerCnt;
  logic [STEP_W-1:0]  step;
  logic               profLatched;
  logic [7:0]         cfgByte [NUM_CFG];
  logic [7:0]         colCheck;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      profLatched <= 1'b0;
    end else if (strobe.latchProfile) begin
      profLatched <= profileSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrTimer) begin
      timerCnt <= '0;
    end else if (strobe.runTimer && !timerDone) begin
      timerCnt <= timerCnt + 1'b1;
    end
  end

  assign timerDone = (timerCnt == TIMER_LAST);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrStep) begin
      step <= '0;
    end else if (strobe.incStep && step != STEP_LAST) begin
      step <= step + 1'b1;
    end
  end

  assign lastStep = (step == STEP_LAST);

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    assign cfgByte[g] = profileByte(profLatched, g);
  end

  always_comb begin
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < NUM_CFG; i++) acc = acc ^ cfgByte[i];
    colCheck = ~acc;
  end

  always_comb begin
    logic [STEP_W-1:0] cfgIdx;
    cfgIdx    = step - STEP_CFG0;
    xferIsCfg = (step >= STEP_CFG0);
    xferAddr  = xferIsCfg ? 4'(cfgIdx) : 4'h0;
    xferByte  = 8'h00;
    if (step == STEP_W'(0))              xferByte = CMD_CHIP_RESET;
    else if (step == STEP_W'(1))         xferByte = CMD_CLAMP_OFF;
    else if (step == STEP_LAST)          xferByte = colCheck;
    else begin
      for (int i = 0; i < NUM_CFG; i++) begin
        if (cfgIdx == STEP_W'(i)) xferByte = cfgByte[i];
      end
    end
  end

endmodule

// File: rtl/rxcfg_sequencer.sv
module rxcfg_sequencer
  import rxcfg_pkg::*;
#(
  parameter int CLK_HZ    = 50000000,
  parameter int SETTLE_MS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       sleepReq,
  input  logic       profileSel,
  input  logic       pwrGood,
  output logic       pwrEn,
  output logic       xferReq,
  output logic       xferIsCfg,
  output logic [3:0] xferAddr,
  output logic [7:0] xferByte,
  input  logic       xferDone,
  output logic       ready
);

  localparam int SETTLE_CYC = (CLK_HZ / 1000) * SETTLE_MS;

  seqStrobe_t strobe;
  logic       timerDone;
  logic       lastStep;

  rxcfg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .sleepReq  (sleepReq),
    .pwrGood   (pwrGood),
    .xferDone  (xferDone),
    .timerDone (timerDone),
    .lastStep  (lastStep),
    .strobe    (strobe),
    .pwrEn     (pwrEn),
    .xferReq   (xferReq),
    .ready     (ready)
  );

  rxcfg_datapath #(.SETTLE_CYC(SETTLE_CYC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .profileSel (profileSel),
    .timerDone  (timerDone),
    .lastStep   (lastStep),
    .xferIsCfg  (xferIsCfg),
    .xferAddr   (xferAddr),
    .xferByte   (xferByte)
  );

endmodule

// File: rtl/rxcfg_sequencer_chk.sv
module rxcfg_sequencer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sleepReq,
  input logic       pwrEn,
  input logic       xferReq,
  input logic       xferIsCfg,
  input logic [3:0] xferAddr,
  input logic [7:0] xferByte,
  input logic       xferDone,
  input logic       ready
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && !xferDone && !sleepReq) |=> (xferReq && $stable(xferByte)
      && $stable(xferAddr) && $stable(xferIsCfg)));

  // R4
  req_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferReq && xferDone) |=> !xferReq);

  // R2
  req_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferReq |-> pwrEn);

  // R10
  ready_powered_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> pwrEn);

  // R10
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ready) |-> $past(xferDone && xferReq));

  // R12
  sleep_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    sleepReq |=> (!pwrEn && !xferReq && !ready));

endmodule

bind rxcfg_sequencer rxcfg_sequencer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sleepReq  (sleepReq),
  .pwrEn     (pwrEn),
  .xferReq   (xferReq),
  .xferIsCfg (xferIsCfg),
  .xferAddr  (xferAddr),
  .xferByte  (xferByte),
  .xferDone  (xferDone),
  .ready     (ready)
);

// File: tb/rxcfg_sequencer_bench.sv
`timescale 1ns/1ps
module rxcfg_sequencer_bench;

  localparam int CLK_HZ    = 100000;
  localparam int SETTLE_MS = 10;
  localparam int SETTLE_N  = (CLK_HZ / 1000) * SETTLE_MS;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       sleepReq = 1'b0;
  logic       profileSel = 1'b0;
  logic       pwrGood = 1'b0;
  logic       pwrEn;
  logic       xferReq;
  logic       xferIsCfg;
  logic [3:0] xferAddr;
  logic [7:0] xferByte;
  logic       xferDone = 1'b0;
  logic       ready;

  int checks = 0;
  int failures = 0;
  int pwrLag = 2;
  bit holdLow = 0;
  int logCnt = 0;
  logic       logCfg  [0:15];
  logic [3:0] logAddr [0:15];
  logic [7:0] logByte [0:15];

  always #10 clk = ~clk;

  rxcfg_sequencer #(.CLK_HZ(CLK_HZ), .SETTLE_MS(SETTLE_MS)) u_rxcfg_sequencer (
    .clk(clk), .rstN(rstN), .startReq(startReq), .sleepReq(sleepReq),
    .profileSel(profileSel), .pwrGood(pwrGood), .pwrEn(pwrEn),
    .xferReq(xferReq), .xferIsCfg(xferIsCfg), .xferAddr(xferAddr),
    .xferByte(xferByte), .xferDone(xferDone), .ready(ready)
  );

  function automatic logic [7:0] cfgOf(input bit prof, input int i);
    logic [7:0] n [0:5];
    logic [7:0] s [0:5];
    n = '{8'hA4, 8'h00, 8'h00, 8'h00, 8'h00, 8'h9F};
    s = '{8'hA8, 8'h80, 8'h00, 8'h00, 8'h00, 8'hD0};
    return prof ? s[i] : n[i];
  endfunction

  function automatic logic [7:0] expByte(input bit prof, input int idx);
    logic [7:0] x;
    if (idx == 0) return 8'hA0;
    if (idx == 1) return 8'h20;
    if (idx < 8) return cfgOf(prof, idx - 2);
    x = 8'h00;
    for (int i = 0; i < 6; i++) x = x ^ cfgOf(prof, i);
    return ~x;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseStart();
    startReq = 1'b1; @(negedge clk); startReq = 1'b0;
  endtask

  // supply model: pwrGood follows pwrEn after pwrLag cycles
  initial begin
    int lag;
    lag = 0;
    forever begin
      @(negedge clk);
      if (holdLow) begin pwrGood = 1'b0; lag = 0; end
      else if (pwrGood != pwrEn) begin
        lag++;
        if (lag >= pwrLag) begin pwrGood = pwrEn; lag = 0; end
      end else lag = 0;
    end
  end

  // serial master model with random latency; R4 field stability
  initial begin
    forever begin
      @(negedge clk);
      if (xferReq && rstN) begin
        int k;
        logic c; logic [3:0] a; logic [7:0] b;
        c = xferIsCfg; a = xferAddr; b = xferByte;
        if (logCnt < 16) begin
          logCfg[logCnt] = c; logAddr[logCnt] = a; logByte[logCnt] = b;
        end
        logCnt++;
        k = int'($urandom_range(0, 4));
        for (int i = 0; i < k; i++) begin
          @(negedge clk);
          if (xferReq)
            check(xferByte == b && xferAddr == a && xferIsCfg == c, "R4 stable",
                  int'(xferByte), int'(b));
        end
        xferDone = 1'b1;
        @(negedge clk);
        xferDone = 1'b0;
        check(!xferReq, "R4 release", int'(xferReq), 0);
      end
    end
  end

  task automatic waitReady(output bit ok);
    ok = 0;
    for (int i = 0; i < SETTLE_N + 400; i++) begin
      @(negedge clk);
      if (ready) begin ok = 1; break; end
    end
  endtask

  task automatic checkLog(input bit prof);
    check(logCnt == 9, "R5 count", logCnt, 9);
    for (int i = 0; i < 9 && i < logCnt; i++) begin
      check(logCfg[i] == (i >= 2), "R5 kind", int'(logCfg[i]), int'(i >= 2));
      check(logAddr[i] == ((i >= 2) ? 4'(i - 2) : 4'd0), "R5 addr",
            int'(logAddr[i]), (i >= 2) ? i - 2 : 0);
      check(logByte[i] == expByte(prof, i),
            (i == 8) ? "R8 check byte" : (prof ? "R7 byte" : "R6 byte"),
            int'(logByte[i]), int'(expByte(prof, i)));
    end
  endtask

  // full run from idle, measuring settle time
  task automatic fullRun(input bit prof);
    bit ok;
    int cnt;
    logCnt = 0;
    profileSel = prof;
    pulseStart();
    check(pwrEn == 1'b1, "R2 pwrEn", int'(pwrEn), 1);
    while (!pwrGood) @(negedge clk);
    cnt = 0;
    while (!xferReq && cnt < SETTLE_N + 10) begin @(negedge clk); cnt++; end
    check(cnt >= SETTLE_N && cnt <= SETTLE_N + 2, "R3 settle", cnt, SETTLE_N + 1);
    waitReady(ok);
    check(ok && pwrEn, "R10 ready", int'(ready), 1);
    checkLog(prof);
  endtask

  task automatic sleepNow();
    sleepReq = 1'b1; @(negedge clk); sleepReq = 1'b0;
    check(!pwrEn && !ready && !xferReq, "R12 sleep",
          int'({pwrEn, ready, xferReq}), 0);
    while (pwrGood) @(negedge clk);
    cycles(2);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    cycles(3);
    // R1 reset state
    check(!pwrEn && !xferReq && !ready, "R1 reset", int'({pwrEn, xferReq, ready}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!pwrEn && !xferReq && !ready, "R1 after reset",
          int'({pwrEn, xferReq, ready}), 0);

    // R2: supply held low stalls the sequence
    holdLow = 1;
    logCnt = 0;
    pulseStart();
    cycles(300);
    check(pwrEn && logCnt == 0, "R2 stall", logCnt, 0);
    holdLow = 0;
    begin bit ok; waitReady(ok); check(ok, "R2 resume", int'(ok), 1); end
    checkLog(1'b0);
    sleepNow();

    // directed both profiles then random runs with random latencies
    fullRun(1'b0);
    sleepNow();
    fullRun(1'b1);
    for (int r = 0; r < 6; r++) begin
      bit p;
      p = 1'($urandom_range(0, 1));
      // new start from ready clears ready (R10)
      if (r % 2 == 0) begin
        sleepNow();
        fullRun(p);
      end else begin
        logCnt = 0;
        profileSel = p;
        pulseStart();
        check(!ready, "R10 cleared by start", int'(ready), 0);
        begin bit ok; waitReady(ok); check(ok, "R10 ready again", int'(ok), 1); end
        checkLog(p);
      end
    end

    // R11 + R9: start pulses mid-run and profile flip after capture
    sleepNow();
    logCnt = 0;
    profileSel = 1'b1;
    pulseStart();
    profileSel = 1'b0;
    cycles(SETTLE_N / 2);
    pulseStart();
    while (logCnt < 4) @(negedge clk);
    pulseStart();
    profileSel = 1'b1;
    begin bit ok; waitReady(ok); check(ok, "R11 completes", int'(ok), 1); end
    checkLog(1'b1);   // R9 profile held at start value; R11 no restart

    // R12 sleep mid-transfer with simultaneous start, then R11 start during power-down wait
    logCnt = 0;
    pulseStart();
    while (logCnt < 3) @(negedge clk);
    pwrLag = 6;
    startReq = 1'b1; sleepReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0; sleepReq = 1'b0;
    check(!pwrEn && !xferReq && !ready, "R12 sleep beats start",
          int'({pwrEn, xferReq, ready}), 0);
    check(pwrGood == 1'b1, "R12 supply lag", int'(pwrGood), 1);
    pulseStart();
    while (pwrGood) @(negedge clk);
    cycles(5);
    check(!pwrEn, "R11 start in power-down ignored", int'(pwrEn), 0);
    pwrLag = 2;

    // recovery after sleep
    fullRun(1'b0);
    sleepNow();
    check(!ready && !pwrEn, "R12 idle", int'({ready, pwrEn}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cycles(150000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule